// File: doc/BRIEF.md
# Thermal Clock Modulation Controller

This block decides, cycle by cycle, whether a core's clock may tick. It produces a clock-gating enable that throttles the core in fixed windows of 2^WIN_LG cycles, which is 8 by default. The enable stays high for the first N cycles of each window and low for the rest. Two sources can ask for throttling. The first is automatic: a hot flag from a temperature comparator, qualified by an automatic enable. The second is software: a small control register holding an on-demand enable and a duty field.

When the part is hot, automatic mode can use one of two methods. The first is clock modulation at a fixed half duty. The second is a one-cycle request to an external performance-state transition unit. If both methods are enabled, the transition method wins. If the transition method fails to cool the part within a programmable number of cycles, a force option adds modulation on top of it. A newly computed duty is latched only when a window closes, so a window never runs with a mix of two duties.

Top module: `thermal_throttle`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `clkEn` is 1, `throttleActive` is 0 and `xtnReq` is 0.
- R2: With `ctrlReg[4]`=1, with `ctrlReg[3:1]`=N where N is from 1 to 7, and with no automatic takeover, `clkEn` is 1 in cycles 0..N-1 of each 8-cycle window and 0 in the rest. This holds whatever the state of `hotIn`.
- R3: A duty field of 0 is reserved and means no modulation. When no modulation is in force, `clkEn` stays 1 and `throttleActive` is 0 unless a transition is in progress.
- R4: When `autoEn`=1, `hotIn`=1, `modEn`=1 and `xtnEn`=0, `clkEn` is 1 in cycles 0..3 of each window and 0 in cycles 4..7.
- R5: When automatic mode has taken over, the on-demand setting is ignored and the half duty of R4 applies.
- R6: When `autoEn`=1, `hotIn`=1 and `xtnEn`=1, the transition method takes precedence. Modulation stays off, `clkEn` stays 1, and `throttleActive` is 1.
- R7: `xtnReq` is a one-cycle pulse. It appears in the cycle after the transition condition of R6 becomes true, and again after each later start of that condition.
- R8: Suppose `forceMod`=1 and `modEn`=1, and the transition condition has held for `coolLimit` consecutive cycles. Then half-duty modulation starts at the next window boundary, while the transition remains in force.
- R9: A change of the requested duty takes effect only at the start of the next window. Cycle 0 of every window has `clkEn`=1, and once `clkEn` falls it stays 0 until the window ends.
- R10: `ctrlReg[0]` has no effect on any output.
- R11: When `autoEn`=1 and `hotIn`=1 but both `modEn` and `xtnEn` are 0, automatic mode does not take over, and the on-demand setting of R2 governs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low synchronous reset |
| hotIn | input | 1 | Temperature above trip point |
| autoEn | input | 1 | Automatic throttling enable |
| modEn | input | 1 | Clock modulation method enabled |
| xtnEn | input | 1 | Performance-state transition method enabled |
| forceMod | input | 1 | Add modulation when the transition fails to cool |
| coolLimit | input | COOL_W (12) | Hot cycles allowed after a transition before it is judged insufficient |
| ctrlReg | input | WIN_LG+2 (5) | Bit 4 on-demand enable, bits 3:1 duty N, bit 0 ignored |
| clkEn | output | 1 | Clock-gating enable |
| throttleActive | output | 1 | Modulation or transition in force |
| xtnReq | output | 1 | One-cycle transition request |

## Verification
The checker keeps its own window phase, counted from the release of reset. It therefore assumes that reset is released synchronously and that the clock runs without gaps afterwards. It also assumes that `hotIn`, the enables and `ctrlReg` are sampled cleanly at each edge. The stimulus changes them only shortly after a rising edge and holds each setting for at least two full windows before its effect is measured. The reference window position in the bench comes from the same count of edges since reset.

// File: rtl/thermal_throttle_pkg.sv
package thermal_throttle_pkg;

  // Widest duty / phase field the strobe carries; WIN_LG must stay below it.
  localparam int STROBE_W = 8;

  typedef struct packed {
    logic                loadDuty;   // window closes at this edge
    logic [STROBE_W-1:0] nextDuty;   // duty to hold for the next window
    logic [STROBE_W-1:0] phase;      // position inside the current window
  } modStrobe_t;

endpackage

// File: rtl/cool_timer.sv
module cool_timer #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             armed,
  input  logic [CNT_W-1:0] limit,
  output logic             expired
);

  logic [CNT_W-1:0] hotCycles;

  // Counts edges spent with the transition in force; saturates.
  always_ff @(posedge clk) begin
    if (!rstN)
      hotCycles <= '0;
    else if (!armed)
      hotCycles <= '0;
    else if (hotCycles != {CNT_W{1'b1}})
      hotCycles <= hotCycles + 1'b1;
  end

  assign expired = armed && (hotCycles >= limit);

endmodule

// File: rtl/throttle_arbiter.sv
module throttle_arbiter
  import thermal_throttle_pkg::*;
#(
  parameter int WIN_LG = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hotIn,
  input  logic              autoEn,
  input  logic              modEn,
  input  logic              xtnEn,
  input  logic              forceMod,
  input  logic              demandOn,
  input  logic [WIN_LG-1:0] demandDuty,
  input  logic              coolFail,
  output modStrobe_t        strobe,
  output logic              xtnCond,
  output logic              xtnReq
);

  localparam int              WIN       = 1 << WIN_LG;
  localparam logic [WIN_LG:0] FULL_DUTY = (WIN_LG + 1)'(WIN);
  localparam logic [WIN_LG:0] HALF_DUTY = (WIN_LG + 1)'(WIN / 2);

  logic [WIN_LG-1:0] phase;
  logic [WIN_LG:0]   reqDuty;
  logic              autoHot;
  logic              autoOwns;
  logic              xtnPrev;

  // Free-running window position.
  always_ff @(posedge clk) begin
    if (!rstN) phase <= '0;
    else       phase <= phase + 1'b1;
  end

  assign autoHot  = autoEn && hotIn;
  assign autoOwns = autoHot && (modEn || xtnEn);
  assign xtnCond  = autoHot && xtnEn;

  // Source arbitration: automatic over on-demand, transition over modulation.
  always_comb begin
    reqDuty = FULL_DUTY;
    if (autoOwns) begin
      if (!xtnEn)
        reqDuty = HALF_DUTY;
      else if (forceMod && modEn && coolFail)
        reqDuty = HALF_DUTY;
    end else if (demandOn && (demandDuty != '0)) begin
      reqDuty = {1'b0, demandDuty};
    end
  end

  // Edge detect on the transition condition gives a one-cycle request.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      xtnPrev <= 1'b0;
      xtnReq  <= 1'b0;
    end else begin
      xtnPrev <= xtnCond;
      xtnReq  <= xtnCond && !xtnPrev;
    end
  end

  always_comb begin
    strobe          = '0;
    strobe.loadDuty = (phase == {WIN_LG{1'b1}});
    strobe.nextDuty = STROBE_W'(reqDuty);
    strobe.phase    = STROBE_W'(phase);
  end

endmodule

// File: rtl/throttle_window.sv
module throttle_window
  import thermal_throttle_pkg::*;
#(
  parameter int WIN_LG = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  modStrobe_t strobe,
  output logic       clkEn,
  output logic       modActive
);

  localparam int              WIN       = 1 << WIN_LG;
  localparam logic [WIN_LG:0] FULL_DUTY = (WIN_LG + 1)'(WIN);

  logic [WIN_LG:0]   heldDuty;
  logic [WIN_LG-1:0] pos;
  logic [STROBE_W-1:0] unusedDutyHi;
  logic [STROBE_W-1:0] unusedPhaseHi;

  assign pos           = strobe.phase[WIN_LG-1:0];
  assign unusedDutyHi  = strobe.nextDuty;
  assign unusedPhaseHi = strobe.phase;

  // Duty is only replaced when a window closes.
  always_ff @(posedge clk) begin
    if (!rstN)
      heldDuty <= FULL_DUTY;
    else if (strobe.loadDuty)
      heldDuty <= strobe.nextDuty[WIN_LG:0];
  end

  assign clkEn     = ({1'b0, pos} < heldDuty);
  assign modActive = (heldDuty != FULL_DUTY);

endmodule

// File: rtl/thermal_throttle.sv
module thermal_throttle
  import thermal_throttle_pkg::*;
#(
  parameter int WIN_LG = 3,
  parameter int COOL_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hotIn,
  input  logic              autoEn,
  input  logic              modEn,
  input  logic              xtnEn,
  input  logic              forceMod,
  input  logic [COOL_W-1:0] coolLimit,
  input  logic [WIN_LG+1:0] ctrlReg,
  output logic              clkEn,
  output logic              throttleActive,
  output logic              xtnReq
);

  modStrobe_t strobe;
  logic       xtnCond;
  logic       coolFail;
  logic       modActive;
  logic       unusedCtrlLsb;

  assign unusedCtrlLsb = ctrlReg[0];

  cool_timer #(.CNT_W(COOL_W)) u_cool (
    .clk    (clk),
    .rstN   (rstN),
    .armed  (xtnCond),
    .limit  (coolLimit),
    .expired(coolFail)
  );

  throttle_arbiter #(.WIN_LG(WIN_LG)) u_arb (
    .clk       (clk),
    .rstN      (rstN),
    .hotIn     (hotIn),
    .autoEn    (autoEn),
    .modEn     (modEn),
    .xtnEn     (xtnEn),
    .forceMod  (forceMod),
    .demandOn  (ctrlReg[WIN_LG+1]),
    .demandDuty(ctrlReg[WIN_LG:1]),
    .coolFail  (coolFail),
    .strobe    (strobe),
    .xtnCond   (xtnCond),
    .xtnReq    (xtnReq)
  );

  throttle_window #(.WIN_LG(WIN_LG)) u_win (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .clkEn    (clkEn),
    .modActive(modActive)
  );

  assign throttleActive = modActive || xtnCond;

endmodule

// File: rtl/thermal_throttle_chk.sv
module thermal_throttle_chk #(
  parameter int WIN_LG = 3
) (
  input logic clk,
  input logic rstN,
  input logic hotIn,
  input logic autoEn,
  input logic xtnEn,
  input logic clkEn,
  input logic throttleActive,
  input logic xtnReq
);

  logic [WIN_LG-1:0] chkPhase;

  always_ff @(posedge clk) begin
    if (!rstN) chkPhase <= '0;
    else       chkPhase <= chkPhase + 1'b1;
  end

  AST_WINDOW_OPENS_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (chkPhase == '0) |-> clkEn); // R9

  AST_NO_REGROW: assert property (@(posedge clk) disable iff (!rstN)
    ((chkPhase != '0) && !$past(clkEn)) |-> !clkEn); // R9

  AST_IDLE_FULL_CLOCK: assert property (@(posedge clk) disable iff (!rstN)
    !throttleActive |-> clkEn); // R3

  AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    xtnReq |=> !xtnReq); // R7

  AST_REQ_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    xtnReq |-> $past(autoEn && hotIn && xtnEn)); // R6

endmodule

bind thermal_throttle thermal_throttle_chk #(.WIN_LG(WIN_LG)) u_chk (
  .clk           (clk),
  .rstN          (rstN),
  .hotIn         (hotIn),
  .autoEn        (autoEn),
  .xtnEn         (xtnEn),
  .clkEn         (clkEn),
  .throttleActive(throttleActive),
  .xtnReq        (xtnReq)
);

// File: tb/thermal_throttle_test.sv
`timescale 1ns/1ps
module thermal_throttle_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hotIn = 1'b0, autoEn = 1'b0, modEn = 1'b0, xtnEn = 1'b0, forceMod = 1'b0;
  logic [11:0] coolLimit = 12'd10;
  logic [4:0]  ctrlReg = 5'd0;
  logic        clkEn, throttleActive, xtnReq;

  int checks = 0;
  int fails  = 0;
  int cycCount = 0;
  bit done = 0;

  typedef struct {
    int    cyc;
    int    kind;   // 0 clkEn, 1 throttleActive, 2 xtnReq
    bit    val;
    string tag;
  } expItem_t;

  expItem_t expQ[$];

  thermal_throttle uut (
    .clk(clk), .rstN(rstN), .hotIn(hotIn), .autoEn(autoEn), .modEn(modEn),
    .xtnEn(xtnEn), .forceMod(forceMod), .coolLimit(coolLimit), .ctrlReg(ctrlReg),
    .clkEn(clkEn), .throttleActive(throttleActive), .xtnReq(xtnReq)
  );

  always #2 clk = ~clk;

  always @(posedge clk) if (rstN) cycCount <= cycCount + 1;

  task automatic checkBit(bit act, bit exp, string tag, string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s cycle %0d actual=%0b expected=%0b", tag, what, cycCount, act, exp);
    end
  endtask

  // Monitor: pops expectations that fall due in the current cycle.
  always @(negedge clk) begin
    while (expQ.size() > 0 && expQ[0].cyc <= cycCount) begin
      expItem_t it;
      it = expQ.pop_front();
      if (it.cyc == cycCount) begin
        case (it.kind)
          0:       checkBit(clkEn, it.val, it.tag, "clkEn");
          1:       checkBit(throttleActive, it.val, it.tag, "throttleActive");
          default: checkBit(xtnReq, it.val, it.tag, "xtnReq");
        endcase
      end
    end
  end

  function automatic bit dutyBit(int cyc, int n);
    return (cyc % 8) < n;
  endfunction

  task automatic push(int cyc, int kind, bit val, string tag);
    expItem_t it;
    it.cyc = cyc; it.kind = kind; it.val = val; it.tag = tag;
    expQ.push_back(it);
  endtask

  task automatic nextCycle();
    @(posedge clk); #1;
  endtask

  task automatic waitUntil(int cyc);
    while (cycCount < cyc) nextCycle();
  endtask

  // Driver: inputs were just changed in this cycle; old duty until the next
  // window boundary, new duty for two windows after it (8 = unthrottled).
  task automatic expectChange(int oldN, int newN, string tag);
    int c = cycCount;
    int w = (c / 8 + 1) * 8;
    for (int cy = c + 1; cy < w + 16; cy++) begin
      int n = (cy < w) ? oldN : newN;
      push(cy, 0, dutyBit(cy, n), tag);
      push(cy, 1, n != 8, tag);
    end
    waitUntil(w + 16);
  endtask

  initial begin
    int c, eff, t;
    repeat (4) @(negedge clk);
    checkBit(clkEn, 1'b1, "R1", "clkEn in reset");
    checkBit(throttleActive, 1'b0, "R1", "throttleActive in reset");
    checkBit(xtnReq, 1'b0, "R1", "xtnReq in reset");
    @(posedge clk); #1 rstN = 1'b1;
    @(negedge clk);
    checkBit(clkEn, 1'b1, "R1", "clkEn after reset");
    checkBit(xtnReq, 1'b0, "R1", "xtnReq after reset");
    nextCycle();

    // On-demand duties; hot without autoEn has no say
    ctrlReg = 5'b1_011_0;                  expectChange(8, 3, "R2");
    ctrlReg = 5'b1_111_1;                  expectChange(3, 7, "R2 R10");
    hotIn = 1'b1;                          expectChange(7, 7, "R2");
    ctrlReg = 5'b1_001_0;                  expectChange(7, 1, "R2 R9");
    ctrlReg = 5'b1_001_1;                  expectChange(1, 1, "R10");
    ctrlReg = 5'b1_000_0;                  expectChange(1, 8, "R3");

    // Automatic half duty overrides on-demand
    hotIn = 1'b0; ctrlReg = 5'b1_110_0;    expectChange(8, 6, "R2");
    autoEn = 1'b1; modEn = 1'b1; hotIn = 1'b1; expectChange(6, 4, "R5");
    ctrlReg = 5'b0;                        expectChange(4, 4, "R4");
    hotIn = 1'b0;                          expectChange(4, 8, "R4");

    // No method enabled: hot ignored, on-demand governs
    modEn = 1'b0; hotIn = 1'b1; ctrlReg = 5'b1_010_0; expectChange(8, 2, "R11");
    ctrlReg = 5'b0; hotIn = 1'b0;          expectChange(2, 8, "R11");

    // Transition method wins over modulation, no force
    modEn = 1'b1; xtnEn = 1'b1; forceMod = 1'b0; coolLimit = 12'd10;
    nextCycle();
    hotIn = 1'b1; c = cycCount;
    push(c + 1, 2, 1'b1, "R7");
    push(c + 2, 2, 1'b0, "R7");
    for (int cy = c + 1; cy < c + 25; cy++) begin
      push(cy, 0, 1'b1, "R6");
      push(cy, 1, 1'b1, "R6");
    end
    waitUntil(c + 25);
    hotIn = 1'b0; nextCycle(); nextCycle();
    hotIn = 1'b1; c = cycCount;
    push(c, 2, 1'b0, "R7");
    push(c + 1, 2, 1'b1, "R7");
    push(c + 2, 2, 1'b0, "R7");
    waitUntil(c + 4);
    hotIn = 1'b0;
    waitUntil(((cycCount / 8) + 2) * 8);

    // Force: modulation joins after coolLimit hot cycles
    forceMod = 1'b1; coolLimit = 12'd10;
    nextCycle();
    hotIn = 1'b1; c = cycCount;
    t = c + 10;
    while ((t % 8) != 7) t++;
    eff = t + 1;
    push(c + 1, 2, 1'b1, "R8");
    for (int cy = c + 1; cy < eff + 16; cy++) begin
      push(cy, 0, (cy < eff) ? 1'b1 : dutyBit(cy, 4), "R8");
      push(cy, 1, 1'b1, "R8");
    end
    waitUntil(eff + 16);
    hotIn = 1'b0;                          expectChange(4, 8, "R8");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule